// File: doc/BRIEF.md
# Dual-Rail Bit-Serial Spiking Adder/Subtractor

This block adds or subtracts two binary numbers one bit per clock, least significant bit first. Every bit travels as a pair of spike lines. A spike on the true line alone is a logic 1, and a spike on the complement line alone is a logic 0. The arithmetic is built only from two threshold neuron primitives. A high-pass neuron fires when two or more of its inputs spike in a step. A low-pass neuron fires when exactly one of its inputs spikes. With two inputs these act as AND and XOR.

The carry is held in a two-state machine with the states `ST_C0` and `ST_C1`. Nothing outside the block can write it. The only way to set up the carry is through a leading bit placed in front of the payload:
- A step where both effective operands are 0 forces the carry to 0 (transition `ST_C1 -> ST_C0`, or a stay in `ST_C0`).
- A step where both effective operands are 1 forces the carry to 1 (transition `ST_C0 -> ST_C1`, or a stay in `ST_C1`).

Any other valid step moves the state according to the full-adder carry. A quiet step or a faulty step keeps the state.

In subtract mode the two rails of the second operand are exchanged, which inverts it. A leading step with the first operand at 1 and the second operand's logic value at 0 then loads the carry with the +1 that two's-complement subtraction needs. A per-cycle error flag reports a lost spike or a pair of conflicting spikes.

Top module: `spk_serial_adder`

## Requirements
- R1: While `rst` is high at a clock edge, the block clears `sum_t`, `sum_f` and `err`, and the carry state goes to `ST_C0`. After reset, a payload sent with no leading bit adds with a carry-in of 0.
- R2: A step in which all four input rails are low is quiet. After that edge both sum rails are low and `err` is low, and the carry state is unchanged.
- R3: For a valid step, the block registers the sum bit one cycle after its input pair. The sum bit is a XOR b' XOR carry, where b' is b in add mode and NOT b in subtract mode. A sum of 1 gives `sum_t`=1 and `sum_f`=0. A sum of 0 gives `sum_t`=0 and `sum_f`=1.
- R4: The carry out of each valid step is the carry-in of the next valid step. With `sub_mode`=0 and a leading step of a=0 and b=0, the 4-bit payload that follows produces (a+b) mod 16 on the sum stream, least significant bit first.
- R5: A leading valid step in which both effective operands are 0 leaves the carry at 0, whatever its earlier value.
- R6: A leading valid step in which both effective operands are 1 leaves the carry at 1, whatever its earlier value. With `sub_mode`=1 (rails of b exchanged), this leading step is a=1 with b's logic value at 0. The 4-bit payload that follows then produces (a-b) mod 16.
- R7: A step is faulty if an operand has both rails high, or if exactly one operand has no rail high. After a faulty step, `err` is 1 for that one cycle and both sum rails are low. The carry state is unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Step clock |
| rst | input | 1 | Synchronous active-high reset |
| sub_mode | input | 1 | 1 exchanges the rails of operand b (subtract) |
| a_t | input | 1 | Operand a, true rail |
| a_f | input | 1 | Operand a, complement rail |
| b_t | input | 1 | Operand b, true rail |
| b_f | input | 1 | Operand b, complement rail |
| sum_t | output | 1 | Registered sum, true rail |
| sum_f | output | 1 | Registered sum, complement rail |
| err | output | 1 | Registered flag: the previous step was faulty |

## Verification
Every pair of 4-bit operands is sent in add mode after a zero leading step, and again in subtract mode after a ones leading step. These two sweeps separate a wrong carry chain from a wrong rail swap, and a wrong carry preset from a wrong sum function.

Random operations then insert quiet gaps between the leading step and the payload. A carry that is lost or disturbed while the input is quiet shows up as a wrong result.

Directed cases cover the following:
- They drop one rail, and they drive both rails together.
- They send a payload straight after reset.
- They place a faulty step between a carry-setting leading step and a zero payload. This separates holding the carry across a fault from clearing it on the fault.

// File: rtl/spk_pkg.sv
package spk_pkg;
    typedef enum logic {
        ST_C0 = 1'b0,
        ST_C1 = 1'b1
    } carry_state_t;
endpackage

// File: rtl/spk_hp_neuron.sv
module spk_hp_neuron #(
    parameter int N_IN = 2
) (
    input  logic [N_IN-1:0] spk_in,
    output logic            fire
);
    localparam int CW = $clog2(N_IN + 1);
    logic [CW-1:0] cnt;

    always_comb begin
        cnt = '0;
        for (int i = 0; i < N_IN; i++) begin
            cnt = cnt + CW'(spk_in[i]);
        end
    end

    assign fire = (cnt >= CW'(2));
endmodule

// File: rtl/spk_lp_neuron.sv
module spk_lp_neuron #(
    parameter int N_IN = 2
) (
    input  logic [N_IN-1:0] spk_in,
    output logic            fire
);
    localparam int CW = $clog2(N_IN + 1);
    logic [CW-1:0] cnt;

    always_comb begin
        cnt = '0;
        for (int i = 0; i < N_IN; i++) begin
            cnt = cnt + CW'(spk_in[i]);
        end
    end

    assign fire = (cnt == CW'(1));
endmodule

// File: rtl/spk_rail_monitor.sv
module spk_rail_monitor #(
    parameter int N_OPS = 2
) (
    input  logic [N_OPS-1:0] rail_t,
    input  logic [N_OPS-1:0] rail_f,
    output logic             all_ok,
    output logic             all_quiet
);
    logic [N_OPS-1:0] op_ok;
    logic [N_OPS-1:0] op_quiet;

    for (genvar g = 0; g < N_OPS; g++) begin : g_op
        assign op_ok[g]    = rail_t[g] ^ rail_f[g];
        assign op_quiet[g] = ~(rail_t[g] | rail_f[g]);
    end

    assign all_ok    = &op_ok;
    assign all_quiet = &op_quiet;
endmodule

// File: rtl/spk_serial_adder.sv
module spk_serial_adder
    import spk_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic sub_mode,
    input  logic a_t,
    input  logic a_f,
    input  logic b_t,
    input  logic b_f,
    output logic sum_t,
    output logic sum_f,
    output logic err
);
    carry_state_t state, state_nx;

    logic be_t, be_f;
    logic in_ok, in_quiet, fault;
    logic c_rail;
    logic x_ab, g_ab, x_fb, s_fire, sn_fire, p_c, c_next;

    // Rail exchange performs the inversion for subtraction
    assign be_t = sub_mode ? b_f : b_t;
    assign be_f = sub_mode ? b_t : b_f;

    spk_rail_monitor #(.N_OPS(2)) u_mon (
        .rail_t   ({a_t, be_t}),
        .rail_f   ({a_f, be_f}),
        .all_ok   (in_ok),
        .all_quiet(in_quiet)
    );
    assign fault  = ~in_ok & ~in_quiet;
    assign c_rail = (state == ST_C1);

    // First half adder: XOR and AND neurons on the true rails
    spk_lp_neuron #(.N_IN(2)) u_x_ab (.spk_in({a_t, be_t}), .fire(x_ab));
    spk_hp_neuron #(.N_IN(2)) u_g_ab (.spk_in({a_t, be_t}), .fire(g_ab));
    // Second half adder with the carry spike
    spk_lp_neuron #(.N_IN(2)) u_sum  (.spk_in({x_ab, c_rail}), .fire(s_fire));
    spk_hp_neuron #(.N_IN(2)) u_p_c  (.spk_in({x_ab, c_rail}), .fire(p_c));
    // The two carry terms never fire together, so LP merges them
    spk_lp_neuron #(.N_IN(2)) u_cout (.spk_in({g_ab, p_c}), .fire(c_next));
    // Complement sum: (not a) xor b xor c, built from the a complement rail
    spk_lp_neuron #(.N_IN(2)) u_x_fb (.spk_in({a_f, be_t}), .fire(x_fb));
    spk_lp_neuron #(.N_IN(2)) u_sumn (.spk_in({x_fb, c_rail}), .fire(sn_fire));

    // Carry state transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_C0: if (in_ok && c_next)  state_nx = ST_C1;
            ST_C1: if (in_ok && !c_next) state_nx = ST_C0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_C0;
        else     state <= state_nx;
    end

    // Registered outputs
    always_ff @(posedge clk) begin
        if (rst) begin
            sum_t <= 1'b0;
            sum_f <= 1'b0;
            err   <= 1'b0;
        end else begin
            sum_t <= in_ok & s_fire;
            sum_f <= in_ok & sn_fire;
            err   <= fault;
        end
    end

    // R7
    err_rails_low_chk: assert property (@(posedge clk) disable iff (rst)
        err |-> (!sum_t && !sum_f));
    // R3
    sum_dual_rail_chk: assert property (@(posedge clk) disable iff (rst)
        in_ok |=> (sum_t ^ sum_f));
    // R2
    quiet_hold_chk: assert property (@(posedge clk) disable iff (rst)
        in_quiet |=> (!sum_t && !sum_f && !err && $stable(state)));
    // R7
    fault_hold_chk: assert property (@(posedge clk) disable iff (rst)
        fault |=> (err && $stable(state)));
    // R6
    ones_preset_chk: assert property (@(posedge clk) disable iff (rst)
        (in_ok && a_t && be_t) |=> (state == ST_C1));
    // R5
    zeros_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (in_ok && a_f && be_f) |=> (state == ST_C0));
    // R1
    spikes_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({sum_t, sum_f, err}));
endmodule

// File: tb/sim_spk_serial_adder.sv
module sim_spk_serial_adder;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sub_mode = 1'b0;
    logic a_t = 1'b0, a_f = 1'b0, b_t = 1'b0, b_f = 1'b0;
    logic sum_t, sum_f, err;
    int checks = 0;
    int errors = 0;
    logic o_t, o_f, o_e;

    always #10 clk = ~clk;

    spk_serial_adder u0 (
        .clk(clk), .rst(rst), .sub_mode(sub_mode),
        .a_t(a_t), .a_f(a_f), .b_t(b_t), .b_f(b_f),
        .sum_t(sum_t), .sum_f(sum_f), .err(err)
    );

    function automatic logic [3:0] ref_result(input logic s, input logic [3:0] a, input logic [3:0] b);
        return s ? 4'(a - b) : 4'(a + b);
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Drive raw rails at negedge, let one edge pass, sample at next negedge
    task automatic step_raw(input logic at, input logic af, input logic bt, input logic bf);
        a_t = at; a_f = af; b_t = bt; b_f = bf;
        @(posedge clk);
        @(negedge clk);
        o_t = sum_t; o_f = sum_f; o_e = err;
    endtask

    task automatic step_bit(input logic a, input logic b);
        step_raw(a, ~a, b, ~b);
    endtask

    task automatic step_quiet(input string req);
        step_raw(0, 0, 0, 0);
        check(req, {o_t, o_f, o_e}, 0);
    endtask

    task automatic payload(input string req, input logic [3:0] a, input logic [3:0] b, input logic [3:0] exp);
        logic [3:0] got = '0;
        int bad = 0;
        for (int i = 0; i < 4; i++) begin
            step_bit(a[i], b[i]);
            got[i] = o_t;
            if ((o_t ^ o_f) != 1'b1 || o_e) bad++;
        end
        check({req, " rails"}, bad, 0);
        check(req, int'(got), int'(exp));
    endtask

    task automatic run_op(input logic s, input logic [3:0] a, input logic [3:0] b, input int gap);
        sub_mode = s;
        if (s) step_bit(1'b1, 1'b0);   // R6 ones leading step (b rails swapped)
        else   step_bit(1'b0, 1'b0);   // R5 zero leading step
        for (int g = 0; g < gap; g++) step_quiet("R2 gap");
        payload(s ? "R6 sub" : "R4 add", a, b, ref_result(s, a, b));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        @(negedge clk);
        @(negedge clk);
        check("R1 reset outputs", {sum_t, sum_f, err}, 0);
        rst = 1'b0;
        step_quiet("R2 idle after reset");
        // R1: carry 0 after reset, no leading step
        payload("R1 carry after reset", 4'd7, 4'd9, 4'd0);

        // R7: lost spike on a, carry preserved across fault
        sub_mode = 1'b0;
        step_bit(1'b1, 1'b1);                  // carry set
        step_raw(0, 0, 1, 0);
        check("R7 lost rail err", o_e, 1);
        check("R7 lost rail outputs", {o_t, o_f}, 0);
        payload("R7 carry held", 4'd0, 4'd0, 4'd1);
        // R7: conflicting rails on b, carry 0 preserved
        step_bit(1'b0, 1'b0);
        step_raw(1, 0, 1, 1);
        check("R7 conflict err", o_e, 1);
        check("R7 conflict outputs", {o_t, o_f}, 0);
        step_raw(1, 1, 0, 0);
        check("R7 both faulty err", o_e, 1);
        step_quiet("R7 err one cycle");
        payload("R7 carry 0 held", 4'd15, 4'd0, 4'd15);
        // R5: zero leading step clears a set carry
        step_bit(1'b1, 1'b1);
        step_bit(1'b0, 1'b0);
        payload("R5 clear", 4'd3, 4'd4, 4'd7);
        // R6: ones leading step sets a clear carry in add mode
        step_bit(1'b0, 1'b0);
        step_bit(1'b1, 1'b1);
        payload("R6 set", 4'd3, 4'd4, 4'd8);
        // R3: single bit sums
        step_bit(1'b0, 1'b0);
        step_bit(1'b1, 1'b0);
        check("R3 sum one", {o_t, o_f}, 2);
        step_bit(1'b0, 1'b0);
        check("R3 sum zero", {o_t, o_f}, 1);

        // Exhaustive 4-bit add and subtract
        for (int s = 0; s < 2; s++)
            for (int a = 0; a < 16; a++)
                for (int b = 0; b < 16; b++)
                    run_op(s[0], a[3:0], b[3:0], 0);

        // Random with quiet gaps
        for (int n = 0; n < 300; n++)
            run_op(1'($urandom), 4'($urandom), 4'($urandom), int'($urandom % 3));

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule